// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Claim/Complete

This block gathers level-sensitive request lines from up to 31 peripherals and presents them to one processor context through a single external-interrupt output. Each source has a latched pending flag, an enable flag and a 3-bit urgency level. One global threshold masks every source whose level does not exceed it. Source number 0 is reserved and never takes part.

Software reaches the controller through a plain 32-bit register bus. When the interrupt output rises, the handler reads the claim register. That read returns the number of the most urgent eligible source and moves it into service, so the controller ignores further requests from it. When the handler has finished, it writes the same number back to the claim register. That write releases the source, which can then latch a new request.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every urgency level, the enable word, the threshold, all pending flags and all in-service flags are zero. The output is low and a claim read returns 0.
- R2: The urgency level of source n is read and written at byte offset 4*n (offsets 0x000 to 0x07C). Only bits [2:0] are stored. The entry for ID 0 always reads 0 and ignores writes.
- R3: A pending, enabled source is eligible only when its level is strictly greater than the threshold (offset 0x200000, bits [2:0]). A level of 0 is never eligible.
- R4: Bit n of the enable word (offset 0x2000) enables source n, and bit 0 always reads 0. A disabled source never raises the output and is never returned by a claim.
- R5: A read at offset 0x200004 returns the ID of the eligible source with the highest level, and on a tie the lowest ID. It returns 0 when no source is eligible.
- R6: A claim read that returns a nonzero ID clears that source's pending flag and puts it in service. While it is in service, its request line is ignored.
- R7: Writing an in-service ID (1 to 31, upper bits zero) to offset 0x200004 ends its service, and the source can then latch a new request. A write naming ID 0 or a source not in service has no effect.
- R8: The output is high exactly when at least one eligible source exists, and it follows the register state in the same cycle.
- R9: The pending word (offset 0x1000, bit n is source n) is read-only, and bit 0 reads 0. A high request line sets the flag on the next clock edge only while the source is neither pending nor in service.
- R10: Reads of unmapped offsets return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcIrq | input | 32 | Level request lines; bit n belongs to source n, and bit 0 is ignored |
| busAddr | input | 22 | Byte offset from the controller base |
| busWrEn | input | 1 | Write strobe; takes effect at the clock edge |
| busRdEn | input | 1 | Read strobe; a claim read takes effect at the clock edge |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, valid in the same cycle as busRdEn |
| extIrq | output | 1 | External interrupt request to the processor |

## Verification
The assertions assume that a read and a write never target the claim register in the same cycle, and that request lines change only between clock edges. The stimulus never raises both strobes together and drives every input just after the falling edge. Request lines stay high across a claim and a completion, so the bench shows both that the controller blocks a source in service and that a source re-arms after release. Several sources are given equal levels, and the threshold is moved across those levels to cover the tie-break and the masking boundary.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int SRC_COUNT = 32;
  localparam int PRIO_W    = 3;
  localparam int ID_W      = $clog2(SRC_COUNT);
  localparam int OFF_W     = 22;
  localparam int DATA_W    = 32;

  localparam logic [OFF_W-1:0] PEND_OFF  = 22'h001000;
  localparam logic [OFF_W-1:0] EN_OFF    = 22'h002000;
  localparam logic [OFF_W-1:0] THR_OFF   = 22'h200000;
  localparam logic [OFF_W-1:0] CLAIM_OFF = 22'h200004;

  typedef enum logic [2:0] {
    RD_NONE, RD_PRIO, RD_PEND, RD_EN, RD_THR, RD_CLAIM
  } rd_sel_e;

  // Strobes from the bus decoder to the register core
  typedef struct packed {
    logic            wrPrio;
    logic            wrEnable;
    logic            wrThresh;
    logic            doClaim;
    logic            doComplete;
    logic [ID_W-1:0] idx;
    rd_sel_e         rdSel;
  } strobe_t;
endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import prio_irq_pkg::*;
#(
  parameter int OFF_BITS  = OFF_W,
  parameter int DATA_BITS = DATA_W,
  parameter int IDX_BITS  = ID_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [OFF_BITS-1:0]  busAddr,
  input  logic                 busWrEn,
  input  logic                 busRdEn,
  input  logic [DATA_BITS-1:0] busWrData,
  output strobe_t              strobes
);
  logic                inPrio;
  logic [IDX_BITS-1:0] compId;
  logic                compOk;

  assign inPrio = (busAddr[OFF_BITS-1:IDX_BITS+2] == '0);
  assign compId = busWrData[IDX_BITS-1:0];
  assign compOk = (busWrData[DATA_BITS-1:IDX_BITS] == '0) && (compId != '0);

  // A write takes precedence when both strobes are raised together
  always_comb begin
    strobes       = '0;
    strobes.rdSel = RD_NONE;
    if (busWrEn) begin
      if (inPrio) begin
        strobes.wrPrio = 1'b1;
        strobes.idx    = busAddr[IDX_BITS+1:2];
      end else if (busAddr == EN_OFF) begin
        strobes.wrEnable = 1'b1;
      end else if (busAddr == THR_OFF) begin
        strobes.wrThresh = 1'b1;
      end else if (busAddr == CLAIM_OFF && compOk) begin
        strobes.doComplete = 1'b1;
        strobes.idx        = compId;
      end
    end else if (busRdEn) begin
      if (inPrio) begin
        strobes.rdSel = RD_PRIO;
        strobes.idx   = busAddr[IDX_BITS+1:2];
      end else if (busAddr == PEND_OFF) begin
        strobes.rdSel = RD_PEND;
      end else if (busAddr == EN_OFF) begin
        strobes.rdSel = RD_EN;
      end else if (busAddr == THR_OFF) begin
        strobes.rdSel = RD_THR;
      end else if (busAddr == CLAIM_OFF) begin
        strobes.rdSel   = RD_CLAIM;
        strobes.doClaim = 1'b1;
      end
    end
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrPrio, strobes.wrEnable, strobes.wrThresh,
              strobes.doComplete, strobes.doClaim})); // R10
  AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && !busWrEn && !inPrio && busAddr != PEND_OFF && busAddr != EN_OFF &&
     busAddr != THR_OFF && busAddr != CLAIM_OFF) |-> strobes.rdSel == RD_NONE); // R10
endmodule

// File: rtl/irq_core.sv
module irq_core
  import prio_irq_pkg::*;
#(
  parameter int NSRC      = SRC_COUNT,
  parameter int LVL_BITS  = PRIO_W,
  parameter int IDX_BITS  = ID_W,
  parameter int DATA_BITS = DATA_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NSRC-1:0]      srcIrq,
  input  strobe_t              strobes,
  input  logic [DATA_BITS-1:0] busWrData,
  output logic [DATA_BITS-1:0] busRdData,
  output logic                 extIrq
);
  logic [LVL_BITS-1:0] prio [NSRC];
  logic [NSRC-1:0]     pending;
  logic [NSRC-1:0]     inService;
  logic [NSRC-1:0]     enable;
  logic [LVL_BITS-1:0] threshold;
  logic [NSRC-1:0]     eligible;
  logic [NSRC-1:0]     setMask;
  logic [IDX_BITS-1:0] bestId;
  logic [LVL_BITS-1:0] bestPrio;
  logic                claimHit;

  // Eligibility: pending, enabled and strictly above the threshold
  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      eligible[i] = (i != 0) && pending[i] && enable[i] && (prio[i] > threshold);
    end
  end

  // Winner: highest level; a scan in ascending ID keeps the lowest ID on a tie
  always_comb begin
    bestId   = '0;
    bestPrio = '0;
    for (int i = 1; i < NSRC; i++) begin
      if (eligible[i] && (bestId == '0 || prio[i] > bestPrio)) begin
        bestId   = IDX_BITS'(i);
        bestPrio = prio[i];
      end
    end
  end

  assign extIrq   = |eligible;
  assign claimHit = strobes.doClaim && (bestId != '0);
  assign setMask  = srcIrq & ~pending & ~inService;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NSRC; i++) prio[i] <= '0;
      pending   <= '0;
      inService <= '0;
    end else begin
      for (int i = 0; i < NSRC; i++) begin
        if (i != 0) begin
          if (strobes.wrPrio && strobes.idx == IDX_BITS'(i))
            prio[i] <= busWrData[LVL_BITS-1:0];
          if (claimHit && bestId == IDX_BITS'(i))
            pending[i] <= 1'b0;
          else if (setMask[i])
            pending[i] <= 1'b1;
          if (claimHit && bestId == IDX_BITS'(i))
            inService[i] <= 1'b1;
          else if (strobes.doComplete && strobes.idx == IDX_BITS'(i))
            inService[i] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable    <= '0;
      threshold <= '0;
    end else begin
      if (strobes.wrEnable) enable <= busWrData[NSRC-1:0] & ~NSRC'(1);
      if (strobes.wrThresh) threshold <= busWrData[LVL_BITS-1:0];
    end
  end

  always_comb begin
    case (strobes.rdSel)
      RD_PRIO:  busRdData = DATA_BITS'(prio[strobes.idx]);
      RD_PEND:  busRdData = DATA_BITS'(pending);
      RD_EN:    busRdData = DATA_BITS'(enable);
      RD_THR:   busRdData = DATA_BITS'(threshold);
      RD_CLAIM: busRdData = DATA_BITS'(bestId);
      default:  busRdData = '0;
    endcase
  end

  AST_PEND_SVC_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    (pending & inService) == '0); // R6
  AST_CLAIM_MARKS: assert property (@(posedge clk) disable iff (!rstN)
    claimHit |=> inService[$past(bestId)] && !pending[$past(bestId)]); // R6
  AST_BEST_ABOVE_THR: assert property (@(posedge clk) disable iff (!rstN)
    (bestId != '0) |-> (prio[bestId] > threshold) && (prio[bestId] != '0)); // R3
  AST_BEST_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    (bestId != '0) |-> enable[bestId] && pending[bestId]); // R4
  AST_IRQ_AGREES: assert property (@(posedge clk) disable iff (!rstN)
    extIrq == (bestId != '0)); // R8
  AST_COMPLETE_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doComplete && inService[strobes.idx]) |=> !inService[$past(strobes.idx)]); // R7
  AST_ID0_UNUSED: assert property (@(posedge clk) disable iff (!rstN)
    !pending[0] && !inService[0] && !enable[0]); // R9
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       srcIrq,
  input  logic [21:0]       busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic              extIrq
);
  strobe_t strobes;

  irq_bus_decode #(
    .OFF_BITS(OFF_W), .DATA_BITS(DATA_W), .IDX_BITS(ID_W)
  ) uDecode (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .strobes(strobes)
  );

  irq_core #(
    .NSRC(SRC_COUNT), .LVL_BITS(PRIO_W), .IDX_BITS(ID_W), .DATA_BITS(DATA_W)
  ) uCore (
    .clk(clk), .rstN(rstN), .srcIrq(srcIrq), .strobes(strobes),
    .busWrData(busWrData), .busRdData(busRdData), .extIrq(extIrq)
  );
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  localparam logic [21:0] A_PEND  = 22'h001000;
  localparam logic [21:0] A_EN    = 22'h002000;
  localparam logic [21:0] A_THR   = 22'h200000;
  localparam logic [21:0] A_CLAIM = 22'h200004;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN;
  logic [31:0] srcIrq;
  logic [21:0] busAddr;
  logic        busWrEn, busRdEn;
  logic [31:0] busWrData;
  logic [31:0] busRdData;
  logic        extIrq;

  prio_irq_ctrl u0 (
    .clk(clk), .rstN(rstN), .srcIrq(srcIrq), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData), .extIrq(extIrq)
  );

  int nChk = 0, nFail = 0;
  bit finished = 0;
  logic [31:0] curIrq = '0;

  // Behavioural reference state
  int mPrio[32];
  bit mPend[32], mSvc[32], mEn[32];
  int mThr;

  function automatic int mBest();
    int best = 0, bp = 0;
    for (int i = 1; i < 32; i++)
      if (mPend[i] && mEn[i] && mPrio[i] > mThr && (best == 0 || mPrio[i] > bp)) begin
        best = i; bp = mPrio[i];
      end
    return best;
  endfunction

  function automatic logic [31:0] mRead(input logic [21:0] a);
    logic [31:0] w = '0;
    if (a < 22'h80) return (a[6:2] == 0) ? 32'd0 : 32'(mPrio[a[6:2]]);
    if (a == A_PEND) begin for (int i = 1; i < 32; i++) w[i] = mPend[i]; return w; end
    if (a == A_EN)   begin for (int i = 1; i < 32; i++) w[i] = mEn[i];   return w; end
    if (a == A_THR)   return 32'(mThr);
    if (a == A_CLAIM) return 32'(mBest());
    return 32'd0;
  endfunction

  task automatic mUpdate(input logic [21:0] a, input bit we, input bit re,
                         input logic [31:0] wd, input logic [31:0] irq);
    int b = mBest();
    bit oPend[32] = mPend;
    bit oSvc[32]  = mSvc;
    for (int i = 1; i < 32; i++)
      if (irq[i] && !oPend[i] && !oSvc[i]) mPend[i] = 1;
    if (re && !we && a == A_CLAIM && b != 0) begin mPend[b] = 0; mSvc[b] = 1; end
    if (we) begin
      if (a < 22'h80 && a[6:2] != 0) mPrio[a[6:2]] = int'(wd[2:0]);
      else if (a == A_EN) for (int i = 1; i < 32; i++) mEn[i] = wd[i];
      else if (a == A_THR) mThr = int'(wd[2:0]);
      else if (a == A_CLAIM && wd >= 1 && wd <= 31 && oSvc[wd[4:0]]) mSvc[wd[4:0]] = 0;
    end
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One bus cycle; output and read data compared against the model before the edge
  task automatic step(input logic [21:0] a, input bit we, input bit re,
                      input logic [31:0] wd, input string tag);
    @(negedge clk);
    busAddr = a; busWrEn = we; busRdEn = re; busWrData = wd; srcIrq = curIrq;
    #1;
    check({tag, " R8 irq"}, {31'd0, extIrq}, {31'd0, mBest() != 0});
    if (re) check({tag, " read"}, busRdData, mRead(a));
    @(posedge clk);
    mUpdate(a, we, re, wd, curIrq);
  endtask

  task automatic wr(input logic [21:0] a, input logic [31:0] d, input string tag);
    step(a, 1, 0, d, tag);
  endtask
  task automatic rd(input logic [21:0] a, input string tag);
    step(a, 0, 1, 32'd0, tag);
  endtask
  task automatic idle(input string tag);
    step(22'd0, 0, 0, 32'd0, tag);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    rstN = 0; srcIrq = '0; busAddr = '0; busWrEn = 0; busRdEn = 0; busWrData = '0;
    for (int i = 0; i < 32; i++) begin mPrio[i] = 0; mPend[i] = 0; mSvc[i] = 0; mEn[i] = 0; end
    mThr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;

    // R1 reset state
    rd(22'h00C, "R1 prio3"); rd(A_PEND, "R1 pend"); rd(A_EN, "R1 en");
    rd(A_THR, "R1 thr"); rd(A_CLAIM, "R1 claim");

    // R2 level registers
    wr(22'h00C, 32'd2, "R2"); wr(22'h014, 32'd5, "R2"); wr(22'h01C, 32'd5, "R2");
    wr(22'h024, 32'd0, "R2"); wr(22'h000, 32'd7, "R2 id0"); wr(22'h02C, 32'hFF, "R2 mask");
    rd(22'h000, "R2 id0"); rd(22'h00C, "R2 prio3"); rd(22'h02C, "R2 prio11");

    // R10 unmapped
    wr(22'h003000, 32'hFFFF, "R10 wr"); rd(22'h003000, "R10"); rd(22'h000100, "R10");

    // R4 enable word, bit 0 reads zero
    wr(A_EN, 32'hFFFF_FFFF, "R4"); rd(A_EN, "R4 en");

    // R9 level latch into pending
    curIrq = (32'd1 << 3) | (32'd1 << 5) | (32'd1 << 7) | (32'd1 << 9);
    idle("R9");
    curIrq = 32'd1 << 5;
    rd(A_PEND, "R9 pend"); wr(A_PEND, 32'd0, "R9 ro"); rd(A_PEND, "R9 ro");

    // R5 ordering with tie, R6 blocking, R3 level 0
    rd(A_CLAIM, "R5 tie"); rd(A_PEND, "R6 blocked"); idle("R6");
    rd(A_CLAIM, "R5 next"); rd(A_CLAIM, "R5 low"); rd(A_CLAIM, "R3 prio0");
    rd(A_PEND, "R3 pend9");

    // R7 bogus completions, then real one
    wr(A_CLAIM, 32'd0, "R7 id0"); wr(A_CLAIM, 32'd12, "R7 idle");
    wr(A_CLAIM, 32'd9, "R7 pend"); wr(A_CLAIM, 32'h25, "R7 big");
    rd(A_PEND, "R7 nochg"); rd(A_CLAIM, "R7 still");
    wr(A_CLAIM, 32'd5, "R7 done"); idle("R7 relatch"); rd(A_PEND, "R7 pend");
    rd(A_CLAIM, "R7 reclaim");

    // R3 threshold boundary
    curIrq = '0;
    wr(A_CLAIM, 32'd5, "R3"); wr(A_CLAIM, 32'd7, "R3"); wr(A_CLAIM, 32'd3, "R3");
    curIrq = (32'd1 << 5) | (32'd1 << 7);
    idle("R3"); curIrq = '0;
    wr(A_THR, 32'd5, "R3"); idle("R3 masked"); rd(A_CLAIM, "R3 equal");
    wr(A_THR, 32'd4, "R3"); rd(A_CLAIM, "R3 above");

    // R4 disabled source skipped
    wr(A_EN, 32'hFFFF_FF7F, "R4"); idle("R4 off"); rd(A_CLAIM, "R4 skip");
    wr(A_EN, 32'hFFFF_FFFF, "R4"); rd(A_CLAIM, "R4 on");

    // R9 bit 0 ignored
    curIrq = 32'd1; idle("R9"); rd(A_PEND, "R9 id0"); curIrq = '0;
    idle("end");

    finished = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule